// File: doc/BRIEF.md
# Packed SIMD Add/Subtract and Left-Shift Execution Unit

This unit carries out one packed operation on a pair of 64-bit operands per clock. The destination operand supplies the first input and is replaced by the result. The source operand supplies the second input, or the shift count for a shift. A lane-size select splits both operands into eight 8-bit, four 16-bit, two 32-bit or one 64-bit lane. Lane 0 always sits in the least significant bits.

Add and subtract act on each lane on its own. Each lane wraps around, clamps as a signed value or clamps as an unsigned value, as the saturation select chooses. The logical left shift moves every lane left by the same count and fills the vacated bits with zeros. The result is registered, and a valid strobe follows an accepted operation by one clock. The unit produces no condition flags.

Top module: `simd_addshift_unit`

## Requirements
- R1: Encodings: op_sel 0 = add, 1 = subtract, 2 or 3 = logical left shift. lane_sel 0/1/2/3 = 8/16/32/64-bit lanes, with lane k in bits [k*W +: W]. sat_sel 0 or 3 = wraparound, 1 = signed saturation, 2 = unsigned saturation. With wraparound, add gives (dst + src) mod 2^W in each lane, and no carry crosses a lane boundary.
- R2: With wraparound, subtract gives (dst - src) mod 2^W in each lane, and no borrow crosses a lane boundary.
- R3: Signed saturation (sat_sel 1) on 8-bit or 16-bit lanes clamps an overflowing lane to 2^(W-1)-1 and an underflowing lane to -2^(W-1). Lanes that do not overflow hold the exact result.
- R4: Unsigned saturation (sat_sel 2) on 8-bit or 16-bit lanes clamps an add overflow to all ones and a subtract underflow to zero.
- R5: A saturation request with 32-bit or 64-bit lanes has no effect, and the result equals wraparound.
- R6: The shift moves every lane left by the count src mod 2^64 when that count is less than the lane width W, and fills with zeros. sat_sel has no effect on shifts.
- R7: When the full 64-bit count is at least W, every lane of the shift result is zero. High count bits are never ignored.
- R8: out_valid rises exactly one clock after in_valid is sampled high, and it is low one clock after in_valid is sampled low. result holds its value on cycles with in_valid low.
- R9: Asserting rst_n low clears result and out_valid at once, during reset and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted on this edge |
| op_sel | input | 2 | 0 add, 1 subtract, 2/3 left shift |
| lane_sel | input | 2 | 0/1/2/3 = 8/16/32/64-bit lanes |
| sat_sel | input | 2 | 0/3 wrap, 1 signed sat, 2 unsigned sat |
| dst_op | input | 64 | Destination operand (first input) |
| src_op | input | 64 | Source operand or shift count |
| out_valid | output | 1 | Result valid strobe |
| result | output | 64 | Registered result replacing the destination |

## Verification
Assertions check the valid timing on every cycle. They also check that the result holds while idle, that an out-of-range shift count yields zero, and that each saturating lane moves in the right direction: an unsigned add never shrinks, an unsigned subtract never grows, and a signed add with a non-negative source never decreases. The exact clamp values, the lane isolation at every size, the fallback to wraparound on wide lanes and the handling of counts with only high bits set can only be shown by the bench. The bench compares the registered result with its behavioural lane-by-lane model on every clock, under directed and random operands.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned MIN_LW = 8;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_SHL  = 2'd2,
    OP_SHL2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SAT_WRAP  = 2'd0,
    SAT_SGN   = 2'd1,
    SAT_UNS   = 2'd2,
    SAT_WRAP2 = 2'd3
  } sat_e;
endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub
  import simd_pkg::*;
#(
  parameter int unsigned LW        = 8,
  parameter bit          ALLOW_SAT = 1'b1
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic          sub_i,
  input  logic [1:0]    sat_i,
  output logic [LW-1:0] y_o
);
  logic [LW:0]   ext;
  logic [LW-1:0] wrap;
  logic          cout;
  logic          s_ovf;

  always_comb begin
    ext   = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
    wrap  = ext[LW-1:0];
    cout  = ext[LW];
    s_ovf = (sub_i ? (a_i[LW-1] != b_i[LW-1]) : (a_i[LW-1] == b_i[LW-1]))
            && (wrap[LW-1] != a_i[LW-1]);
    y_o   = wrap;
    if (ALLOW_SAT) begin
      if (sat_i == SAT_SGN && s_ovf)
        y_o = a_i[LW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
      else if (sat_i == SAT_UNS && cout)
        y_o = sub_i ? '0 : '1;
    end
  end

  // R4 / R3: saturating lanes move in the direction of the operation
  always_comb begin
    if (ALLOW_SAT && sat_i == SAT_UNS && !sub_i)
      a_r4_uns_add_no_shrink: assert (y_o >= a_i);
    if (ALLOW_SAT && sat_i == SAT_UNS && sub_i)
      a_r4_uns_sub_no_grow: assert (y_o <= a_i);
    if (ALLOW_SAT && sat_i == SAT_SGN && !sub_i && !b_i[LW-1])
      a_r3_sgn_add_no_drop: assert ($signed(y_o) >= $signed(a_i));
  end
endmodule

// File: rtl/simd_packed_addsub.sv
module simd_packed_addsub
  import simd_pkg::*;
#(
  parameter int unsigned W          = WORD_W,
  parameter int unsigned SAT_MAX_LW = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic [1:0]   sat_i,
  input  logic [1:0]   lane_sel_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned NSIZES = 4;
  logic [W-1:0] per_size [NSIZES];

  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam int unsigned LW = MIN_LW << k;
    localparam int unsigned NL = W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      simd_lane_addsub #(.LW(LW), .ALLOW_SAT(LW <= SAT_MAX_LW)) u_lane (
        .a_i   (a_i[l*LW +: LW]),
        .b_i   (b_i[l*LW +: LW]),
        .sub_i (sub_i),
        .sat_i (sat_i),
        .y_o   (per_size[k][l*LW +: LW])
      );
    end
  end

  assign y_o = per_size[lane_sel_i];
endmodule

// File: rtl/simd_packed_shl.sv
module simd_packed_shl
  import simd_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] cnt_i,
  input  logic [1:0]   lane_sel_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned NSIZES = 4;
  logic [W-1:0] per_size [NSIZES];

  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam int unsigned LW = MIN_LW << k;
    localparam int unsigned NL = W / LW;
    localparam int unsigned CW = $clog2(LW);
    logic over;
    assign over = (cnt_i >= W'(LW));
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign per_size[k][l*LW +: LW] = over ? '0 : (a_i[l*LW +: LW] << cnt_i[CW-1:0]);
    end
  end

  assign y_o = per_size[lane_sel_i];
endmodule

// File: rtl/simd_result_reg.sv
module simd_result_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0] data_d;
  logic         valid_d;

  always_comb begin
    valid_d = load_i;
    data_d  = load_i ? data_i : data_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_d;
      data_o  <= data_d;
    end
  end
endmodule

// File: rtl/simd_addshift_unit.sv
module simd_addshift_unit
  import simd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  op_sel,
  input  logic [1:0]  lane_sel,
  input  logic [1:0]  sat_sel,
  input  logic [63:0] dst_op,
  input  logic [63:0] src_op,
  output logic        out_valid,
  output logic [63:0] result
);
  logic [WORD_W-1:0] arith_y;
  logic [WORD_W-1:0] shl_y;
  logic [WORD_W-1:0] next_y;

  simd_packed_addsub #(.W(WORD_W), .SAT_MAX_LW(16)) u_arith (
    .a_i        (dst_op),
    .b_i        (src_op),
    .sub_i      (op_sel == OP_SUB),
    .sat_i      (sat_sel),
    .lane_sel_i (lane_sel),
    .y_o        (arith_y)
  );

  simd_packed_shl #(.W(WORD_W)) u_shl (
    .a_i        (dst_op),
    .cnt_i      (src_op),
    .lane_sel_i (lane_sel),
    .y_o        (shl_y)
  );

  assign next_y = op_sel[1] ? shl_y : arith_y;

  simd_result_reg #(.W(WORD_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (in_valid),
    .data_i  (next_y),
    .valid_o (out_valid),
    .data_o  (result)
  );

  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r7_shift_overrange: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[1] && (src_op >= (64'd8 << lane_sel))) |=> (result == '0));
endmodule

// File: tb/simd_addshift_unit_tb_top.sv
`timescale 1ns/1ps
module simd_addshift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_sel, lane_sel, sat_sel;
  logic [63:0] dst_op, src_op;
  logic        out_valid;
  logic [63:0] result;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] exp_res;
  logic        exp_val;

  always #4 clk = ~clk;

  simd_addshift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .lane_sel(lane_sel), .sat_sel(sat_sel), .dst_op(dst_op), .src_op(src_op),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] ref_calc(input logic [1:0] op, input logic [1:0] ls,
                                           input logic [1:0] sat, input logic [63:0] d,
                                           input logic [63:0] s);
    int lw = 8 << ls;
    int nl = 64 / lw;
    logic [63:0] mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    logic [63:0] r = '0;
    for (int i = 0; i < nl; i++) begin
      logic [63:0] a = (d >> (i * lw)) & mask;
      logic [63:0] b = (s >> (i * lw)) & mask;
      logic [63:0] y;
      int eff = (lw <= 16) ? int'(sat) : 0;
      if (eff == 3) eff = 0;
      if (op >= 2) begin
        y = (s >= 64'(lw)) ? 64'd0 : ((a << s[5:0]) & mask);
      end else if (eff == 0) begin
        y = ((op == 0) ? a + b : a - b) & mask;
      end else if (eff == 2) begin
        longint ua = longint'(a), ub = longint'(b), t;
        t = (op == 0) ? ua + ub : ua - ub;
        if (t < 0) t = 0;
        if (t > (longint'(1) << lw) - 1) t = (longint'(1) << lw) - 1;
        y = 64'(t) & mask;
      end else begin
        longint sa = longint'(a), sb = longint'(b), t;
        if (sa >= (longint'(1) << (lw - 1))) sa -= (longint'(1) << lw);
        if (sb >= (longint'(1) << (lw - 1))) sb -= (longint'(1) << lw);
        t = (op == 0) ? sa + sb : sa - sb;
        if (t > (longint'(1) << (lw - 1)) - 1) t = (longint'(1) << (lw - 1)) - 1;
        if (t < -(longint'(1) << (lw - 1))) t = -(longint'(1) << (lw - 1));
        y = 64'(t) & mask;
      end
      r = r | (y << (i * lw));
    end
    return r;
  endfunction

  // reference model, advanced on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_res <= '0;
      exp_val <= 1'b0;
    end else begin
      exp_val <= in_valid;
      if (in_valid) exp_res <= ref_calc(op_sel, lane_sel, sat_sel, dst_op, src_op);
    end
  end

  task automatic chk(input string tag);
    n_tests++;
    if (result !== exp_res || out_valid !== exp_val) begin
      n_fail++;
      $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
               tag, result, out_valid, exp_res, exp_val);
    end
  endtask

  task automatic lit(input logic [63:0] want, input string tag);
    n_tests++;
    if (result !== want) begin
      n_fail++;
      $display("FAIL %s: result=%h expected %h", tag, result, want);
    end
  endtask

  // called at a negedge: drive, wait one edge, compare at the next negedge
  task automatic step(input logic v, input logic [1:0] op, input logic [1:0] ls,
                      input logic [1:0] sat, input logic [63:0] d, input logic [63:0] s,
                      input string tag);
    in_valid = v; op_sel = op; lane_sel = ls; sat_sel = sat; dst_op = d; src_op = s;
    @(posedge clk);
    @(negedge clk);
    chk(tag);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; op_sel = 0; lane_sel = 0; sat_sel = 0;
    dst_op = '0; src_op = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset state");
    lit(64'd0, "R9 reset result");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 byte add wraps without carry into the next lane
    step(1, 0, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R1");
    lit(64'h0000_0000_0000_0000, "R1 lane isolation");
    step(1, 0, 1, 0, 64'h1234_FFFF_0001_8000, 64'h0001_0001_FFFF_8000, "R1");
    step(1, 0, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R1");
    lit(64'd0, "R1 64-bit wrap");
    // R2 subtract wraps per lane
    step(1, 1, 0, 0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, "R2");
    lit(64'hFFFF_FFFF_FFFF_FFFF, "R2 byte borrow");
    step(1, 1, 2, 0, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006, "R2");
    // R3 signed saturation
    step(1, 0, 0, 1, 64'h7F80_0102_7F80_0000, 64'h0180_0203_7FFF_0000, "R3");
    step(1, 0, 1, 1, 64'h7FFF_8000_1000_0001, 64'h0001_FFFF_2000_0002, "R3");
    lit(64'h7FFF_8000_3000_0003, "R3 word clamp");
    step(1, 1, 0, 1, 64'h8000_0000_0000_007F, 64'h0100_0000_0000_0080, "R3");
    // R4 unsigned saturation
    step(1, 0, 0, 2, 64'hF0F0_0000_0000_00FF, 64'h2010_0000_0000_0001, "R4");
    lit(64'hFFFF_0000_0000_00FF, "R4 add clamp");
    step(1, 1, 1, 2, 64'h0005_0010_0000_0000, 64'h0006_0001_0000_0000, "R4");
    lit(64'h0000_000F_0000_0000, "R4 sub clamp");
    // R5 saturation ignored on wide lanes
    step(1, 0, 2, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R5");
    lit(64'h8000_0000_0000_0000, "R5 dword signed falls back");
    step(1, 0, 3, 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, "R5");
    lit(64'd1, "R5 qword unsigned falls back");
    step(1, 1, 2, 3, 64'd0, 64'd1, "R1");
    // R6 shifts
    step(1, 2, 0, 1, 64'h8181_8181_8181_8181, 64'd1, "R6");
    lit(64'h0202_0202_0202_0202, "R6 byte shift");
    step(1, 3, 1, 2, 64'h1234_5678_9ABC_DEF0, 64'd15, "R6");
    step(1, 2, 3, 0, 64'h0000_0000_0000_0001, 64'd63, "R6");
    lit(64'h8000_0000_0000_0000, "R6 qword shift");
    // R7 count out of range, including high-bit-only counts
    step(1, 2, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8, "R7");
    lit(64'd0, "R7 byte count 8");
    step(1, 2, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R7");
    lit(64'd0, "R7 high count bits");
    step(1, 2, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R7");
    // R8 idle holds, valid drops
    step(1, 0, 0, 0, 64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111, "R8");
    step(0, 1, 2, 0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1, "R8 idle");
    lit(64'h1213_1415_1617_1819, "R8 hold");
    step(0, 2, 0, 0, 64'h0, 64'h0, "R8 idle");
    step(1, 1, 0, 0, 64'h0, 64'h0, "R8 resume");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] op = 2'($urandom), ls = 2'($urandom), sat = 2'($urandom);
      logic [63:0] d = {$urandom, $urandom};
      logic [63:0] s = {$urandom, $urandom};
      if (op[1] && ($urandom % 4 != 0)) s = 64'($urandom % 70);
      step(($urandom % 5) != 0, op, ls, sat, d, s,
           op[1] ? "R6 random" : (sat == 1 ? "R3 random" : (sat == 2 ? "R4 random" : "R2 random")));
    end

    // R9 asynchronous reset mid-run
    step(1, 0, 0, 0, 64'h5555_5555_5555_5555, 64'h1, "R9 pre");
    rst_n = 1'b0;
    #1;
    n_tests++;
    if (result !== 64'd0 || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: result=%h valid=%b expected 0 0", result, out_valid);
    end
    @(negedge clk);
    chk("R9 held in reset");
    rst_n = 1'b1;
    step(1, 0, 0, 0, 64'h1, 64'h1, "R9 after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule